// File: doc/BRIEF.md
# Five-Channel Triggered DMA Engine

This block moves bytes or 16-bit words between addresses of an 8-bit memory on behalf of up to five independent channels. Each channel holds its own setup in registers: a start source and destination address, an element count, a priority level, which of 32 event inputs starts it, how each address moves per element, the element size, a transfer mode and whether the first element carries the length. Software arms a channel. The chosen event then starts it. A priority arbiter with round-robin among equals picks one channel per element, and the engine runs that element over a single request/grant memory port.

Each element is read completely before it is written. A word element takes two byte reads (low byte at the lower address) and then two byte writes. Arbitration happens again after every element, so a higher-priority channel can cut into a long block at the next element boundary. When a channel ends, it raises a sticky done flag and a one-cycle interrupt pulse. An abort stops the channel at the next element boundary and leaves no done flag.

Top module: `dmac_top`

## Requirements
- R1: After reset no channel is armed, every done flag and interrupt is 0 and `mem_req` is 0.
- R2: A pulse on `ch_arm[c]` loads the channel's addresses and count. The channel then waits for its selected event, `trig_in[cfg_trig[c]]`. Events on other inputs, and events while the channel is unarmed, cause no memory access.
- R3: For a byte element (`cfg_word`=0) the engine reads the source byte and writes it to the destination. Each address mode field uses 0 = fixed, 1 = increment by the element size, 2 = decrement by the element size, 3 = fixed.
- R4: For a word element (`cfg_word`=1) the engine reads src and src+1, then writes dst and dst+1. The addresses step by 2.
- R5: In single mode (`cfg_mode`=0) each event moves one element. An event that arrives while that channel's element is in progress is stored once, not counted.
- R6: In block mode (`cfg_mode`=1) one event moves the whole count and then disarms the channel. A count of 0 moves one element.
- R7: Setting `cfg_mode` bit 1 makes the mode repeated. On completion the channel reloads its start addresses and count and stays armed.
- R8: With `cfg_lfd`=1 the first element read gives N, its low CW bits. The element is copied, and N further elements follow. `cfg_len` is ignored.
- R9: `cfg_prio` levels are 0 < 1 < 2, and 3 acts as 2. The engine always starts the next element on a pending channel of the highest level, and it re-arbitrates after every element.
- R10: Pending channels of equal level are served one element each in turn (round-robin).
- R11: On completion `done_flag[c]` is set and stays set until `done_clr[c]` is pulsed. `irq[c]` is high for exactly one cycle per completion.
- R12: A pulse on `ch_abort[c]` disarms the channel. If an element is in progress it finishes first. No done flag and no interrupt are produced.
- R13: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_gnt`. Read data is taken when `mem_rvalid` is high, any number of cycles after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | NCH*AW | Start source address per channel |
| cfg_dst | input | NCH*AW | Start destination address per channel |
| cfg_len | input | NCH*CW | Element count per channel |
| cfg_prio | input | NCH*2 | Priority level per channel |
| cfg_trig | input | NCH*TSW | Event input select per channel |
| cfg_mode | input | NCH*2 | bit0 block, bit1 repeated |
| cfg_word | input | NCH | 1 = 16-bit elements |
| cfg_smode | input | NCH*2 | Source address mode |
| cfg_dmode | input | NCH*2 | Destination address mode |
| cfg_lfd | input | NCH | Length taken from first element |
| ch_arm | input | NCH | Arm pulse per channel |
| ch_abort | input | NCH | Abort pulse per channel |
| done_clr | input | NCH | Write-one-to-clear for done flags |
| trig_in | input | NTRIG | Event inputs |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| ch_armed | output | NCH | Channel armed |
| done_flag | output | NCH | Sticky completion flags |
| irq | output | NCH | One-cycle completion pulses |

## Verification
A wrong address register or step shows up as a destination byte that differs from the bench's model. It can also show as a write outside the expected range, and the full memory comparison after each transfer catches it. A wrong count or length latch shows up within a few element times: the number of writes is wrong, or the done flag comes too early or never comes. Arbitration faults appear in the order of writes at the memory port, starting with the first element after two channels become pending. Pending-event and abort faults show as extra or missing writes, or a done flag, before the next event is given.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  // address movement per element
  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_HOLD  = 2'd3
  } amode_e;

  // element engine states
  typedef enum logic [2:0] {
    ES_IDLE,
    ES_RD,
    ES_RWAIT,
    ES_WR,
    ES_DONE
  } est_e;

  // level 3 is served like level 2
  function automatic logic [1:0] prio_level(input logic [1:0] p);
    return (p == 2'd3) ? 2'd2 : p;
  endfunction

endpackage

// File: rtl/dmac_arb.sv
module dmac_arb
  import dmac_pkg::*;
#(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic [2*N-1:0] prio_i,
  input  logic          take_i,
  output logic          vld_o,
  output logic [IW-1:0] gnt_o
);

  logic [IW-1:0] ptr_q;
  logic [1:0]    lv   [N];
  logic [1:0]    best;
  logic          found;
  logic [IW:0]   idx;

  always_comb begin
    best = 2'd0;
    for (int i = 0; i < N; i++) begin
      lv[i] = prio_level(prio_i[2*i +: 2]);
      if (req_i[i] && lv[i] > best) best = lv[i];
    end
    vld_o = |req_i;
    gnt_o = '0;
    found = 1'b0;
    idx   = '0;
    // scan starting after the last granted channel
    for (int k = 1; k <= N; k++) begin
      idx = {1'b0, ptr_q} + (IW+1)'(k);
      if (idx >= (IW+1)'(N)) idx = idx - (IW+1)'(N);
      if (!found && req_i[idx[IW-1:0]] && lv[idx[IW-1:0]] == best) begin
        found = 1'b1;
        gnt_o = idx[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= IW'(N-1);
    else if (take_i) ptr_q <= gnt_o;
  end

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_len,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_word,
  input  logic [1:0]    cfg_smode,
  input  logic [1:0]    cfg_dmode,
  input  logic          cfg_lfd,
  input  logic          arm_i,
  input  logic          abort_i,
  input  logic          clr_i,
  input  logic          trig_i,
  input  logic          start_i,
  input  logic          svc_i,
  input  logic          edone_i,
  input  logic [CW-1:0] len_i,
  output logic          req_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          armed_o,
  output logic          done_o,
  output logic          irq_o
);

  logic          armed_q, pend_q, abt_q, first_q, done_q, irq_q;
  logic [CW-1:0] rem_q;
  logic [AW-1:0] src_q, dst_q;
  logic          blk, rpt, last, stop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [1:0] m,
                                        input logic w);
    logic [AW-1:0] sz;
    sz = w ? AW'(2) : AW'(1);
    if (m == AM_INC)      return a + sz;
    else if (m == AM_DEC) return a - sz;
    else                  return a;
  endfunction

  assign blk  = cfg_mode[0];
  assign rpt  = cfg_mode[1];
  assign last = first_q ? (len_i == '0) : (rem_q <= CW'(1));
  assign stop = abt_q || abort_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0; pend_q <= 1'b0; abt_q <= 1'b0; first_q <= 1'b0;
      done_q  <= 1'b0; irq_q  <= 1'b0; rem_q <= '0;
      src_q   <= '0;   dst_q  <= '0;
    end else begin
      irq_q <= 1'b0;
      if (clr_i) done_q <= 1'b0;
      if (arm_i) begin
        armed_q <= 1'b1; pend_q <= 1'b0; abt_q <= 1'b0;
        src_q <= cfg_src; dst_q <= cfg_dst; rem_q <= cfg_len; first_q <= cfg_lfd;
      end else begin
        if (abort_i && armed_q) abt_q <= 1'b1;
        if (start_i && !blk) pend_q <= 1'b0;
        if (edone_i) begin
          src_q   <= nxt(src_q, cfg_smode, cfg_word);
          dst_q   <= nxt(dst_q, cfg_dmode, cfg_word);
          rem_q   <= first_q ? len_i : rem_q - CW'(1);
          first_q <= 1'b0;
          if (stop) begin
            armed_q <= 1'b0; abt_q <= 1'b0; pend_q <= 1'b0;
          end else if (last) begin
            done_q <= 1'b1; irq_q <= 1'b1; pend_q <= 1'b0;
            if (rpt) begin
              src_q <= cfg_src; dst_q <= cfg_dst; rem_q <= cfg_len; first_q <= cfg_lfd;
            end else begin
              armed_q <= 1'b0;
            end
          end
        end else if (stop && !svc_i) begin
          armed_q <= 1'b0; abt_q <= 1'b0; pend_q <= 1'b0;
        end
        // a stored event wins over the clear in the same cycle
        if (trig_i && armed_q && !stop) pend_q <= 1'b1;
      end
    end
  end

  assign req_o   = armed_q && pend_q && !abt_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign armed_o = armed_q;
  assign done_o  = done_q;
  assign irq_o   = irq_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_q && !clr_i |=> done_q); // R11
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q); // R11
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    edone_i && abt_q |=> !irq_q && !armed_q); // R12

endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int NCH   = 5,
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int NTRIG = 32,
  localparam int TSW  = $clog2(NTRIG),
  localparam int IW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH*AW-1:0] cfg_src,
  input  logic [NCH*AW-1:0] cfg_dst,
  input  logic [NCH*CW-1:0] cfg_len,
  input  logic [NCH*2-1:0]  cfg_prio,
  input  logic [NCH*TSW-1:0] cfg_trig,
  input  logic [NCH*2-1:0]  cfg_mode,
  input  logic [NCH-1:0]    cfg_word,
  input  logic [NCH*2-1:0]  cfg_smode,
  input  logic [NCH*2-1:0]  cfg_dmode,
  input  logic [NCH-1:0]    cfg_lfd,
  input  logic [NCH-1:0]    ch_arm,
  input  logic [NCH-1:0]    ch_abort,
  input  logic [NCH-1:0]    done_clr,
  input  logic [NTRIG-1:0]  trig_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_rvalid,
  output logic [NCH-1:0]    ch_armed,
  output logic [NCH-1:0]    done_flag,
  output logic [NCH-1:0]    irq
);

  est_e          st;
  logic [IW-1:0] ch_q;
  logic          word_q, bidx_q;
  logic [AW-1:0] src_q, dst_q;
  logic [7:0]    b0_q, b1_q;
  logic          req_q, we_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdata_q;

  logic [NCH-1:0] c_req;
  logic [AW-1:0]  c_src [NCH];
  logic [AW-1:0]  c_dst [NCH];
  logic           arb_vld;
  logic [IW-1:0]  arb_gnt;
  logic           take;
  logic [15:0]    len16;
  logic [CW-1:0]  len_val;

  assign take    = (st == ES_IDLE) && arb_vld;
  assign len16   = word_q ? {b1_q, b0_q} : {8'h00, b0_q};
  assign len_val = CW'(len16);

  dmac_arb #(.N(NCH), .IW(IW)) u_arb (
    .clk(clk), .rst(rst), .req_i(c_req), .prio_i(cfg_prio),
    .take_i(take), .vld_o(arb_vld), .gnt_o(arb_gnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmac_chan #(.AW(AW), .CW(CW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .cfg_src  (cfg_src[i*AW +: AW]),
      .cfg_dst  (cfg_dst[i*AW +: AW]),
      .cfg_len  (cfg_len[i*CW +: CW]),
      .cfg_mode (cfg_mode[2*i +: 2]),
      .cfg_word (cfg_word[i]),
      .cfg_smode(cfg_smode[2*i +: 2]),
      .cfg_dmode(cfg_dmode[2*i +: 2]),
      .cfg_lfd  (cfg_lfd[i]),
      .arm_i    (ch_arm[i]),
      .abort_i  (ch_abort[i]),
      .clr_i    (done_clr[i]),
      .trig_i   (trig_in[cfg_trig[i*TSW +: TSW]]),
      .start_i  (take && arb_gnt == IW'(i)),
      .svc_i    (st != ES_IDLE && ch_q == IW'(i)),
      .edone_i  (st == ES_DONE && ch_q == IW'(i)),
      .len_i    (len_val),
      .req_o    (c_req[i]),
      .src_o    (c_src[i]),
      .dst_o    (c_dst[i]),
      .armed_o  (ch_armed[i]),
      .done_o   (done_flag[i]),
      .irq_o    (irq[i])
    );
  end

  // element engine: read all bytes of one element, then write them
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ES_IDLE; ch_q <= '0; word_q <= 1'b0; bidx_q <= 1'b0;
      src_q <= '0; dst_q <= '0; b0_q <= '0; b1_q <= '0;
      req_q <= 1'b0; we_q <= 1'b0; addr_q <= '0; wdata_q <= '0;
    end else begin
      case (st)
        ES_IDLE: if (arb_vld) begin
          ch_q   <= arb_gnt;
          word_q <= cfg_word[arb_gnt];
          src_q  <= c_src[arb_gnt];
          dst_q  <= c_dst[arb_gnt];
          bidx_q <= 1'b0;
          req_q  <= 1'b1;
          we_q   <= 1'b0;
          addr_q <= c_src[arb_gnt];
          st     <= ES_RD;
        end
        ES_RD: if (mem_gnt) begin
          req_q <= 1'b0;
          st    <= ES_RWAIT;
        end
        ES_RWAIT: if (mem_rvalid) begin
          if (!bidx_q) b0_q <= mem_rdata;
          else         b1_q <= mem_rdata;
          req_q <= 1'b1;
          if (word_q && !bidx_q) begin
            bidx_q <= 1'b1;
            addr_q <= src_q + AW'(1);
            st     <= ES_RD;
          end else begin
            bidx_q  <= 1'b0;
            we_q    <= 1'b1;
            addr_q  <= dst_q;
            wdata_q <= word_q ? b0_q : mem_rdata;
            st      <= ES_WR;
          end
        end
        ES_WR: if (mem_gnt) begin
          if (word_q && !bidx_q) begin
            bidx_q  <= 1'b1;
            addr_q  <= dst_q + AW'(1);
            wdata_q <= b1_q;
          end else begin
            req_q <= 1'b0;
            we_q  <= 1'b0;
            st    <= ES_DONE;
          end
        end
        default: st <= ES_IDLE;
      endcase
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // a pending channel above the granted level would be a priority violation
  logic       hi_skip;
  logic [1:0] g_lvl;
  always_comb begin
    g_lvl = 2'd0;
    for (int i = 0; i < NCH; i++)
      if (arb_gnt == IW'(i)) g_lvl = prio_level(cfg_prio[2*i +: 2]);
    hi_skip = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (c_req[i] && prio_level(cfg_prio[2*i +: 2]) > g_lvl) hi_skip = 1'b1;
  end

  AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (rst)
    take |-> !hi_skip); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata)); // R13
  AST_RVALID_WAIT: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> st == ES_RWAIT && !mem_req); // R13

endmodule

// File: tb/tb_dmac_top.sv
module tb_dmac_top;
  localparam int NCH = 5, AW = 16, CW = 16, NTRIG = 32, TSW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH*AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [NCH*CW-1:0] cfg_len = '0;
  logic [NCH*2-1:0]  cfg_prio = '0, cfg_mode = '0, cfg_smode = '0, cfg_dmode = '0;
  logic [NCH*TSW-1:0] cfg_trig = '0;
  logic [NCH-1:0]    cfg_word = '0, cfg_lfd = '0, ch_arm = '0, ch_abort = '0, done_clr = '0;
  logic [NTRIG-1:0]  trig_in = '0;
  logic mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;
  logic [NCH-1:0] ch_armed, done_flag, irq;

  dmac_top dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int gnt_mode = 0;  // 0 always, 1 random, 2 never
  logic [7:0] ram [1024];
  logic [7:0] shadow [1024];
  int wr_count = 0;
  int wlog [64];
  int irq_cnt [NCH];

  initial for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;

  always @(negedge clk)
    mem_gnt <= (gnt_mode == 0) ? 1'b1 : (gnt_mode == 2) ? 1'b0 : ($urandom % 4 != 0);

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        ram[mem_addr[9:0]] <= mem_wdata;
        wlog[wr_count % 64] <= int'(mem_addr);
        wr_count <= wr_count + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= ram[mem_addr[9:0]];
      end
    end
    for (int i = 0; i < NCH; i++) if (irq[i]) irq_cnt[i] <= irq_cnt[i] + 1;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic setc(input int c, input int s, input int d, input int len, input int pr,
                      input int tg, input int md, input bit w, input int sm, input int dm,
                      input bit lf);
    cfg_src[c*AW +: AW]   = AW'(s);
    cfg_dst[c*AW +: AW]   = AW'(d);
    cfg_len[c*CW +: CW]   = CW'(len);
    cfg_prio[c*2 +: 2]    = 2'(pr);
    cfg_trig[c*TSW +: TSW] = TSW'(tg);
    cfg_mode[c*2 +: 2]    = 2'(md);
    cfg_word[c]           = w;
    cfg_smode[c*2 +: 2]   = 2'(sm);
    cfg_dmode[c*2 +: 2]   = 2'(dm);
    cfg_lfd[c]            = lf;
  endtask

  task automatic arm(input int c);
    @(negedge clk); ch_arm[c] = 1'b1; @(negedge clk); ch_arm[c] = 1'b0;
  endtask
  task automatic abort_ch(input int c);
    @(negedge clk); ch_abort[c] = 1'b1; @(negedge clk); ch_abort[c] = 1'b0;
  endtask
  task automatic clr(input int c);
    @(negedge clk); done_clr[c] = 1'b1; @(negedge clk); done_clr[c] = 1'b0;
  endtask
  task automatic pulse(input int t);
    @(negedge clk); trig_in[t] = 1'b1; @(negedge clk); trig_in[t] = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_done(input int c);
    int n = 0;
    while (!done_flag[c] && n < 3000) begin @(negedge clk); n++; end
  endtask
  task automatic sync_shadow();
    for (int i = 0; i < 1024; i++) shadow[i] = ram[i];
  endtask

  function automatic int stepa(input int a, input int m, input int sz);
    if (m == 1) return a + sz;
    if (m == 2) return a - sz;
    return a;
  endfunction

  task automatic model_copy(input int s, input int d, input int n, input bit w,
                            input int sm, input int dm);
    int sa = s, da = d, sz = w ? 2 : 1;
    for (int e = 0; e < n; e++) begin
      for (int b = 0; b < sz; b++) shadow[(da + b) & 1023] = shadow[(sa + b) & 1023];
      sa = stepa(sa, sm, sz);
      da = stepa(da, dm, sz);
    end
  endtask

  function automatic int mism();
    int m = 0;
    for (int i = 0; i < 1024; i++) if (ram[i] !== shadow[i]) m++;
    return m;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base, n0, ok;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) ram[i] = 8'($urandom);
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    chk(ch_armed == 0 && done_flag == 0, "R1 armed/done", int'({ch_armed, done_flag}), 0);
    chk(irq == 0 && mem_req == 0, "R1 irq/req", int'({irq, mem_req}), 0);

    // R2 event selection and unarmed channel
    setc(0, 300, 600, 1, 0, 7, 1, 0, 1, 1, 0);
    setc(1, 310, 610, 5, 0, 9, 0, 0, 1, 1, 0);
    arm(0);
    base = wr_count;
    pulse(8); idle(30);
    chk(wr_count == base, "R2 other event ignored", wr_count - base, 0);
    pulse(9); idle(30);
    chk(wr_count == base, "R2 unarmed ignored", wr_count - base, 0);
    pulse(7); wait_done(0);
    chk(wr_count == base + 1 && done_flag[0], "R2 selected event runs", wr_count - base, 1);
    clr(0);

    // R5 single mode, one element per event, busy event stored once
    arm(1);
    base = wr_count;
    pulse(9); idle(30);
    chk(wr_count == base + 1, "R5 one element", wr_count - base, 1);
    pulse(9); pulse(9); pulse(9); idle(40);
    chk(wr_count == base + 3, "R5 busy event stored once", wr_count - base, 3);
    chk(!done_flag[1] && ch_armed[1], "R5 not yet done", int'(done_flag[1]), 0);
    pulse(9); idle(30); pulse(9); wait_done(1);
    chk(wr_count == base + 5 && done_flag[1], "R5 count reached", wr_count - base, 5);
    chk(!ch_armed[1], "R5 disarmed", int'(ch_armed[1]), 0);
    clr(1);

    // R6 block with count 0 moves one element
    setc(2, 320, 620, 0, 0, 3, 1, 0, 1, 1, 0);
    arm(2); base = wr_count;
    pulse(3); wait_done(2); idle(20);
    chk(wr_count == base + 1, "R6 count zero", wr_count - base, 1);
    chk(!ch_armed[2], "R6 block disarms", int'(ch_armed[2]), 0);
    clr(2);

    // R7 repeated block reloads; R11 sticky flag and single irq
    setc(3, 100, 700, 2, 1, 4, 3, 0, 1, 1, 0);
    arm(3); base = wr_count; n0 = irq_cnt[3];
    pulse(4); wait_done(3); idle(20);
    chk(wr_count == base + 2 && ch_armed[3], "R7 first round", wr_count - base, 2);
    chk(done_flag[3], "R11 flag sticky", int'(done_flag[3]), 1);
    chk(irq_cnt[3] == n0 + 1, "R11 one irq", irq_cnt[3] - n0, 1);
    clr(3); idle(1);
    chk(!done_flag[3], "R11 write one clears", int'(done_flag[3]), 0);
    pulse(4); wait_done(3); idle(5);
    chk(wr_count == base + 4 && wlog[(base + 2) % 64] == 700 && wlog[(base + 3) % 64] == 701,
        "R7 reload addresses", wlog[(base + 3) % 64], 701);
    clr(3);
    abort_ch(3); idle(4);
    chk(!ch_armed[3] && !done_flag[3], "R12 idle abort", int'(ch_armed[3]), 0);

    // R8 length from first element
    ram[400] = 8'd3;
    sync_shadow();
    setc(4, 400, 800, 9, 0, 5, 1, 0, 1, 1, 1);
    arm(4); base = wr_count;
    pulse(5); wait_done(4); idle(5);
    model_copy(400, 800, 4, 0, 1, 1);
    chk(wr_count == base + 4, "R8 element count", wr_count - base, 4);
    chk(mism() == 0, "R8 data", mism(), 0);
    clr(4);

    // R9 highest level first
    setc(0, 300, 620, 3, 0, 12, 1, 0, 1, 1, 0);
    setc(1, 320, 660, 3, 2, 12, 1, 0, 1, 1, 0);
    arm(0); arm(1); base = wr_count;
    pulse(12); wait_done(0); wait_done(1);
    ok = 1;
    for (int k = 0; k < 3; k++) if (wlog[(base + k) % 64] < 660) ok = 0;
    chk(ok == 1, "R9 high level first", wlog[base % 64], 660);
    clr(0); clr(1);

    // R9 preemption at element boundary
    setc(0, 300, 620, 4, 0, 13, 1, 0, 1, 1, 0);
    setc(1, 320, 660, 2, 1, 14, 1, 0, 1, 1, 0);
    arm(0); arm(1); base = wr_count;
    pulse(13);
    while (wr_count < base + 1) @(negedge clk);
    pulse(14); wait_done(0); wait_done(1);
    chk(wr_count == base + 6 && wlog[(base + 5) % 64] < 660, "R9 preempt between elements",
        wlog[(base + 5) % 64], 623);
    clr(0); clr(1);

    // R10 round-robin among equal levels
    setc(2, 330, 680, 3, 1, 15, 1, 0, 1, 1, 0);
    setc(3, 340, 720, 3, 1, 15, 1, 0, 1, 1, 0);
    arm(2); arm(3); base = wr_count;
    pulse(15); wait_done(2); wait_done(3);
    ok = 1;
    for (int k = 1; k < 6; k++)
      if ((wlog[(base + k) % 64] >= 720) == (wlog[(base + k - 1) % 64] >= 720)) ok = 0;
    chk(ok == 1 && wr_count == base + 6, "R10 alternation", wr_count - base, 6);
    clr(2); clr(3);

    // R12 abort while an element waits for the memory
    setc(0, 300, 620, 8, 0, 16, 1, 0, 1, 1, 0);
    arm(0); base = wr_count; n0 = irq_cnt[0];
    gnt_mode = 2;
    pulse(16); idle(5);
    abort_ch(0); idle(3);
    gnt_mode = 0;
    idle(40);
    chk(wr_count == base + 1, "R12 current element finishes", wr_count - base, 1);
    chk(!ch_armed[0] && !done_flag[0] && irq_cnt[0] == n0, "R12 no done",
        int'(done_flag[0]), 0);

    // R3 R4 R13 random transfers with stalls
    gnt_mode = 1;
    sync_shadow();
    for (int it = 0; it < 24; it++) begin
      int c = it % NCH;
      bit w = it[0];
      int len = 1 + int'($urandom % 6);
      int sm = int'($urandom % 3), dm = int'($urandom % 3);
      int s = 300 + int'($urandom % 50), d = 600 + int'($urandom % 50);
      int tg = int'($urandom % 32);
      setc(c, s, d, len, int'($urandom % 4), tg, 1, w, sm, dm, 0);
      model_copy(s, d, len, w, sm, dm);
      arm(c); n0 = irq_cnt[c];
      pulse(tg); wait_done(c); idle(3);
      chk(done_flag[c] && irq_cnt[c] == n0 + 1, w ? "R4 done" : "R3 done",
          int'(done_flag[c]), 1);
      chk(mism() == 0, w ? "R4 R13 memory" : "R3 R13 memory", mism(), 0);
      clr(c);
    end
    gnt_mode = 0;
    idle(5);
    finish_run();
  end

endmodule